// File: doc/BRIEF.md
# Wake-Up Input Sensing Register

This block monitors four external wake lines, already converted to logic levels, while the system is in a low-power state. It reports which line ended that state. A 4-bit control field is loaded through a single-cycle write port. The lines are grouped in two pairs, and each pair has one of four sensing modes: off, high level, low level, or any change of level. A line is first synchronised and then debounced.

In Sleep or Stop mode, the first line that meets its pair's condition raises a one-cycle wake request and latches a source vector. The 4-bit status output shows this latched vector until the first read strobe. After that read, the status output follows the debounced levels of the lines. If the wake came from Stop mode, a watchdog timeout that arrives before the first read wipes the latched vector. Entering a low-power state again discards any latched value that was never read, and re-arms the block.

Top module: `wake_sense`

## Requirements
- R1: After reset the control field is 0000, so all inputs are disabled. wake_req_o is 0 and stat_o is 0000 while every pin is low.
- R2: A pin level counts only after it passes a two-flop synchroniser and then stays unchanged for 4 clock cycles. A new level held long enough appears on the debounced level 6 rising edges after the change. A pulse that lasts 3 cycles has no effect.
- R3: Control bits [1:0] set the mode of inputs 0 and 1. Control bits [3:2] set the mode of inputs 2 and 3.
- R4: The pair code is 00 = off, 01 = wake on a high level, 10 = wake on a low level, 11 = wake on any change of the debounced level.
- R5: mode_i is encoded as 00 Normal, 01 Standby, 10 Sleep, 11 Stop. In Sleep or Stop, wake_req_o pulses for exactly one cycle, one rising edge after the debounced condition holds. A condition already true when the block enters the state wakes it 2 edges after mode_i changes. Further conditions are ignored until mode_i leaves Sleep or Stop.
- R6: After a wake, stat_o shows 1 for the input or inputs that caused it and 0 for all others. This holds in every mode until a read strobe. During the strobe cycle stat_o still shows the latched vector. From the next cycle it shows the live levels.
- R7: When no latched value is pending, stat_o bit i is the debounced level of pin i (1 = high).
- R8: A one-cycle wd_timeout_i after a wake from Stop, but before the first read, clears the latched bits, so stat_o reads 0000 until the read. After a wake from Sleep, a timeout has no effect.
- R9: A new entry into Sleep or Stop discards an unread latched value, so stat_o shows live levels from the edge after entry, and re-arms wake detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | System power mode (00 Normal, 01 Standby, 10 Sleep, 11 Stop) |
| cfg_we_i | input | 1 | Write strobe for the control field |
| cfg_wdata_i | input | 4 | Control field value, two bits per input pair |
| pin_i | input | 4 | Thresholded wake line levels |
| stat_rd_i | input | 1 | Single-cycle status read strobe |
| wd_timeout_i | input | 1 | Watchdog timeout pulse |
| stat_o | output | 4 | Wake source vector or live input levels |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
A pin change driven just after a falling edge reaches the debounced level at the 6th rising edge. It reaches wake_req_o and the latched status at the 7th rising edge. The bench samples at falling edges exactly 6 and 7 cycles later, so both the "not yet" value and the "now" value are checked. A condition already met when the block enters Sleep or Stop is due 2 edges after the mode change. A read strobe or a watchdog pulse takes effect at the next rising edge. Status is therefore sampled once during the strobe cycle and once on the falling edge that follows. Wake pulses are also counted at every falling edge, which shows whether any condition that should be ignored raised a request.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_STANDBY = 2'b01,
    PM_SLEEP   = 2'b10,
    PM_STOP    = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;
endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic chg_o
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic          s1_q, s2_q, lvl_q, lvl_d_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_n;

  always_comb begin
    cnt_d = '0;
    lvl_n = lvl_q;
    if (s2_q != lvl_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) lvl_n = s2_q;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      s1_q    <= pin_i;
      s2_q    <= s1_q;
      lvl_q   <= lvl_n;
      lvl_d_q <= lvl_q;
      cnt_q   <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;
  assign chg_o = lvl_q ^ lvl_d_q;

  // R2: a debounced change only follows a synchronised level seen on consecutive cycles
  p_filter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q && $past(s2_q, 2) == lvl_q));
endmodule

// File: rtl/wake_cond.sv
module wake_cond import wake_pkg::*; (
  input  logic [1:0] sel_i,
  input  logic       lvl_i,
  input  logic       chg_i,
  output logic       hit_o
);
  always_comb begin
    unique case (sense_e'(sel_i))
      SENSE_HIGH: hit_o = lvl_i;
      SENSE_LOW:  hit_o = ~lvl_i;
      SENSE_ANY:  hit_o = chg_i;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wake_sense.sv
module wake_sense import wake_pkg::*; #(
  parameter int N_IN     = 4,
  parameter int FILT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            cfg_we_i,
  input  logic [N_IN-1:0] cfg_wdata_i,
  input  logic [N_IN-1:0] pin_i,
  input  logic            stat_rd_i,
  input  logic            wd_timeout_i,
  output logic [N_IN-1:0] stat_o,
  output logic            wake_req_o
);
  localparam int N_PAIR = N_IN / 2;
  localparam int CFG_W  = 2 * N_PAIR;

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  lvl_vec, chg_vec, hit_vec;
  logic [N_IN-1:0]  src_q, src_d;
  logic             sleep_q, woke_q, woke_d, hold_q, hold_d;
  logic             stop_src_q, stop_src_d, req_q;
  logic             in_low, entry, evt;

  wake_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    wake_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_i[i]),
      .lvl_o(lvl_vec[i]), .chg_o(chg_vec[i]));
    wake_cond u_cond (
      .sel_i(cfg_q[2*(i/2) +: 2]), .lvl_i(lvl_vec[i]),
      .chg_i(chg_vec[i]), .hit_o(hit_vec[i]));
  end

  assign in_low = mode_i[1];
  assign entry  = in_low & ~sleep_q;
  assign evt    = in_low & sleep_q & ~woke_q & (|hit_vec);

  always_comb begin
    woke_d     = woke_q;
    hold_d     = hold_q;
    src_d      = src_q;
    stop_src_d = stop_src_q;
    if (entry) begin
      woke_d     = 1'b0;
      hold_d     = 1'b0;
      src_d      = '0;
      stop_src_d = 1'b0;
    end else if (evt) begin
      woke_d     = 1'b1;
      hold_d     = 1'b1;
      src_d      = hit_vec;
      stop_src_d = (pwr_mode_e'(mode_i) == PM_STOP);
    end else if (stat_rd_i) begin
      hold_d = 1'b0;
    end else if (wd_timeout_i && hold_q && stop_src_q) begin
      src_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q      <= '0;
      sleep_q    <= 1'b0;
      woke_q     <= 1'b0;
      hold_q     <= 1'b0;
      src_q      <= '0;
      stop_src_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i[CFG_W-1:0];
      sleep_q    <= in_low;
      woke_q     <= woke_d;
      hold_q     <= hold_d;
      src_q      <= src_d;
      stop_src_q <= stop_src_d;
      req_q      <= evt;
    end
  end

  assign stat_o     = hold_q ? src_q : lvl_vec;
  assign wake_req_o = req_q;

  // R5: request is a single-cycle pulse
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_req_o |=> !wake_req_o);
  // R5: request only follows a cycle spent in Sleep or Stop
  p_req_mode_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_req_o |-> $past(mode_i[1]));
  // R6: after a read strobe the status follows the debounced levels
  p_live_after_read_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_rd_i && !entry && !evt) |=> (stat_o == lvl_vec));
  // R8: watchdog timeout on an unread wake from Stop empties the status
  p_wdt_clear_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wd_timeout_i && hold_q && stop_src_q && !stat_rd_i && !entry) |=> (stat_o == '0));
endmodule

// File: tb/wake_sense_bench.sv
module wake_sense_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cfg_we;
  logic [3:0] cfg_wdata;
  logic [3:0] pins;
  logic       stat_rd;
  logic       wd_to;
  logic [3:0] stat;
  logic       wake_req;

  int n_chk = 0;
  int n_bad = 0;
  int req_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_sense u_wake_sense (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .pin_i(pins), .stat_rd_i(stat_rd),
    .wd_timeout_i(wd_to), .stat_o(stat), .wake_req_o(wake_req));

  always @(negedge clk) if (wake_req) req_seen++;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic read_status(input logic [3:0] latched, input logic [3:0] live, input string req);
    stat_rd = 1'b1;
    #2 check({req, " strobe cycle"}, stat, latched);
    tick(1);
    stat_rd = 1'b0;
    #2 check({req, " after read"}, stat, live);
  endtask

  task automatic t_reset;
    int base;
    check("R1 stat", stat, 4'b0000);
    check("R1 wake_req", {3'b0, wake_req}, 4'b0000);
    base = req_seen;
    mode = 2'b10; tick(3);
    pins = 4'b0001; tick(10);
    check("R1 cfg reset disables wake", 4'(req_seen - base), 4'd0);
    mode = 2'b00; pins = 4'b0000; tick(8);
  endtask

  task automatic t_filter;
    pins = 4'b0001; tick(3);
    pins = 4'b0000; tick(10);
    check("R2 3-cycle glitch", stat, 4'b0000);
    pins = 4'b0001; tick(5);
    check("R2 level before 6th edge", stat, 4'b0000);
    tick(1);
    check("R2 R7 level at 6th edge", stat, 4'b0001);
    pins = 4'b0000; tick(8);
  endtask

  task automatic t_high_wake;
    int base;
    write_cfg(4'b0001);
    mode = 2'b10; tick(3);
    base = req_seen;
    pins = 4'b0100; tick(10);
    check("R3 pair1 off ignores pin2", 4'(req_seen - base), 4'd0);
    pins = 4'b0110; tick(6);
    check("R5 no request at 6th edge", {3'b0, wake_req}, 4'b0000);
    tick(1);
    check("R5 R4 high-level request", {3'b0, wake_req}, 4'b0001);
    check("R6 R3 latched source", stat, 4'b0010);
    tick(1);
    check("R5 single pulse", {3'b0, wake_req}, 4'b0000);
    base = req_seen;
    pins = 4'b0111; tick(10);
    check("R5 later events ignored", 4'(req_seen - base), 4'd0);
    check("R6 latch held", stat, 4'b0010);
    mode = 2'b00; pins = 4'b0101; tick(8);
    check("R6 latch held in Normal", stat, 4'b0010);
    read_status(4'b0010, 4'b0101, "R6 R7");
  endtask

  task automatic t_stop_low;
    pins = 4'b1111; tick(8);
    write_cfg(4'b1000);
    mode = 2'b11; tick(3);
    pins = 4'b0111; tick(7);
    check("R4 low-level request", {3'b0, wake_req}, 4'b0001);
    check("R6 source in Stop", stat, 4'b1000);
    tick(1);
    wd_to = 1'b1; tick(1); wd_to = 1'b0;
    #2 check("R8 timeout clears Stop latch", stat, 4'b0000);
    tick(1);
    check("R8 cleared until read", stat, 4'b0000);
    read_status(4'b0000, 4'b0111, "R8 R6");
  endtask

  task automatic t_sleep_wd;
    mode = 2'b00; tick(2);
    mode = 2'b10; tick(2);
    check("R5 condition present at entry", {3'b0, wake_req}, 4'b0001);
    check("R6 source at entry", stat, 4'b1000);
    wd_to = 1'b1; tick(1); wd_to = 1'b0;
    #2 check("R8 Sleep wake keeps latch", stat, 4'b1000);
  endtask

  task automatic t_reentry;
    int base;
    mode = 2'b00; tick(2);
    check("R6 unread latch in Normal", stat, 4'b1000);
    write_cfg(4'b0000);
    mode = 2'b10; tick(2);
    check("R9 entry discards latch", stat, 4'b0111);
    base = req_seen;
    pins = 4'b1110; tick(12);
    check("R4 code 00 off", 4'(req_seen - base), 4'd0);
    check("R9 R7 live in Sleep", stat, 4'b1110);
  endtask

  task automatic t_any_change;
    int base;
    write_cfg(4'b0011);
    base = req_seen;
    tick(10);
    check("R4 any-change quiet", 4'(req_seen - base), 4'd0);
    pins = 4'b1100; tick(6);
    check("R4 any-change not yet", {3'b0, wake_req}, 4'b0000);
    tick(1);
    check("R4 any-change request", {3'b0, wake_req}, 4'b0001);
    check("R6 any-change source", stat, 4'b0010);
    mode = 2'b00; tick(1);
    read_status(4'b0010, 4'b1100, "R6");
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; cfg_we = 1'b0; cfg_wdata = 4'b0;
    pins = 4'b0; stat_rd = 1'b0; wd_to = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset;
    t_filter;
    t_high_wake;
    t_stop_low;
    t_sleep_wd;
    t_reentry;
    t_any_change;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary;
      $finish;
    end
  end
endmodule